// File: doc/BRIEF.md
# Display Controller Boot Sequencer

This block brings an external graphics controller, reached over an SPI transaction engine, from power-down into a configured, displaying state. After reset it drives the active-low power-down pin through a low-then-high pulse. It then issues four host commands in a fixed order, with a set pause after each: wake, external-oscillator select, PLL select and core reset. Next it reads the controller's identification register again and again until the expected identity is returned. Only after that does it write the display timing registers. The pixel clock divider is written last, because a nonzero divider turns the display on.

All pauses are counted in milliseconds, and one millisecond is a parameter-set number of pulses on a one-cycle `tick` input. The block talks to the transaction engine through a request/response port. A request is held until the engine pulses `rsp_done`, and for reads `rsp_rdata` is sampled on that pulse. If the identity never appears within a parameter-set number of reads, the block stops and raises `err` instead of hanging. If the sequence completes, `done` stays high until the next reset.

Top module: `disp_boot_seq`

## Requirements
- R1: While reset is asserted and just after it, `pd_n` is low, `req_valid`, `done` and `err` are low, and no request is made while `pd_n` is low. `pd_n` stays low for exactly PD_LOW_MS*TICKS_PER_MS ticks and then goes high.
- R2: After `pd_n` rises, exactly PD_HIGH_MS*TICKS_PER_MS ticks pass before the first request.
- R3: The first four requests are host commands (`req_op` = 0), with the opcode in `req_addr[23:16]` and zeros in `req_addr[15:0]` and `req_wdata`. In order the opcodes are wake 0x00, external oscillator 0x44, PLL select 0x62 and core reset 0x68.
- R4: After the wake, oscillator and PLL commands complete, the block waits exactly WAKE_MS, OSC_MS and PLL_MS milliseconds of ticks before the next request. The first identity read follows the core reset with no tick wait.
- R5: Once raised, `req_valid` and the `req_op`, `req_addr` and `req_wdata` fields stay unchanged until the cycle in which `rsp_done` is high.
- R6: Identity reads use `req_op` = 1 at ID_ADDR and repeat until `rsp_rdata` equals 0x7C on completion. Response data returned for host commands is ignored. No write request is made before the match.
- R7: If POLL_LIMIT reads complete without a match, `err` goes high and stays high, and no further request (and no write) is made.
- R8: After the match, thirteen writes go to CFG_BASE + 4*i for i = 0..12. The first ten are 16-bit writes (`req_op` = 3), in the order horizontal cycle, offset, size, sync0, sync1, then the vertical set in the same order. The next two are 8-bit writes (`req_op` = 2): swizzle, then pixel clock polarity.
- R9: The last write is the 8-bit pixel clock divider at CFG_BASE + 48.
- R10: `done` rises once the last write completes and stays high with no further request until reset, and reset restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing pulse, TICKS_PER_MS per millisecond |
| pd_n | output | 1 | Active-low power-down pin of the controller |
| req_valid | output | 1 | Request pending to the transaction engine |
| req_op | output | 2 | 0 host command, 1 read 8-bit, 2 write 8-bit, 3 write 16-bit |
| req_addr | output | 24 | Register address, or opcode in bits 23:16 for host commands |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Transaction completed (one cycle) |
| rsp_rdata | input | 8 | Read data, valid with rsp_done |
| done | output | 1 | Configuration complete |
| err | output | 1 | Identity poll timed out |

## Verification
The bench counts ticks across each pause. A counter that is off by one, or that keeps running while a request is outstanding, shows up as a wrong tick count in a gap. The identity match is placed on the first read, on a middle read and on exactly the last allowed read, and one run never matches. An off-by-one timeout would either give up on a valid last-read match or issue one extra read. Host-command responses carry the identity value, so a design that checks the identity too early would skip the polling. Distinct register values catch any swap in the write order or the pixel-clock-last rule.

// File: rtl/disp_boot_seq.sv
module disp_boot_seq #(
  parameter int          TICKS_PER_MS = 1000,
  parameter int          PD_LOW_MS    = 20,
  parameter int          PD_HIGH_MS   = 20,
  parameter int          WAKE_MS      = 20,
  parameter int          OSC_MS       = 10,
  parameter int          PLL_MS       = 10,
  parameter int          POLL_LIMIT   = 1000,
  parameter logic [7:0]  CMD_WAKE     = 8'h00,
  parameter logic [7:0]  CMD_EXTOSC   = 8'h44,
  parameter logic [7:0]  CMD_PLL      = 8'h62,
  parameter logic [7:0]  CMD_CORE_RST = 8'h68,
  parameter logic [23:0] ID_ADDR      = 24'h0C0000,
  parameter logic [7:0]  ID_VALUE     = 8'h7C,
  parameter logic [23:0] CFG_BASE     = 24'h102428,
  parameter logic [15:0] H_CYCLE      = 16'd548,
  parameter logic [15:0] H_OFFSET     = 16'd43,
  parameter logic [15:0] H_SIZE       = 16'd480,
  parameter logic [15:0] H_SYNC0      = 16'd0,
  parameter logic [15:0] H_SYNC1      = 16'd41,
  parameter logic [15:0] V_CYCLE      = 16'd292,
  parameter logic [15:0] V_OFFSET     = 16'd12,
  parameter logic [15:0] V_SIZE       = 16'd272,
  parameter logic [15:0] V_SYNC0      = 16'd0,
  parameter logic [15:0] V_SYNC1      = 16'd10,
  parameter logic [15:0] SWIZZLE      = 16'd0,
  parameter logic [15:0] PCLK_POL     = 16'd1,
  parameter logic [15:0] PCLK_DIV     = 16'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  output logic        pd_n,
  output logic        req_valid,
  output logic [1:0]  req_op,
  output logic [23:0] req_addr,
  output logic [15:0] req_wdata,
  input  logic        rsp_done,
  input  logic [7:0]  rsp_rdata,
  output logic        done,
  output logic        err
);

  localparam int NWR    = 13;
  localparam int NWIDE  = 10;
  localparam int MAX_A  = (PD_LOW_MS > PD_HIGH_MS) ? PD_LOW_MS : PD_HIGH_MS;
  localparam int MAX_B  = (WAKE_MS > OSC_MS) ? WAKE_MS : OSC_MS;
  localparam int MAX_C  = (MAX_B > PLL_MS) ? MAX_B : PLL_MS;
  localparam int MAX_MS = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int TW     = $clog2(MAX_MS * TICKS_PER_MS + 1);
  localparam int PW     = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {
    S_PDLO, S_PDHI, S_HOST, S_DELAY, S_POLL, S_WRITE, S_DONE, S_ERR
  } state_t;

  state_t        st;
  logic [TW-1:0] cnt;
  logic [1:0]    cidx;
  logic [PW-1:0] polls;
  logic [3:0]    widx;

  logic [7:0]    opc;
  logic [TW-1:0] hdly;
  logic [TW-1:0] tgt;
  logic [15:0]   wval;
  logic          elapsed;
  logic          last_cmd;

  always_comb begin
    unique case (cidx)
      2'd0: begin opc = CMD_WAKE;     hdly = TW'(WAKE_MS * TICKS_PER_MS); end
      2'd1: begin opc = CMD_EXTOSC;   hdly = TW'(OSC_MS * TICKS_PER_MS);  end
      2'd2: begin opc = CMD_PLL;      hdly = TW'(PLL_MS * TICKS_PER_MS);  end
      default: begin opc = CMD_CORE_RST; hdly = '0; end
    endcase
  end

  always_comb begin
    case (st)
      S_PDLO:  tgt = TW'(PD_LOW_MS * TICKS_PER_MS);
      S_PDHI:  tgt = TW'(PD_HIGH_MS * TICKS_PER_MS);
      default: tgt = hdly;
    endcase
  end

  always_comb begin
    case (widx)
      4'd0:    wval = H_CYCLE;
      4'd1:    wval = H_OFFSET;
      4'd2:    wval = H_SIZE;
      4'd3:    wval = H_SYNC0;
      4'd4:    wval = H_SYNC1;
      4'd5:    wval = V_CYCLE;
      4'd6:    wval = V_OFFSET;
      4'd7:    wval = V_SIZE;
      4'd8:    wval = V_SYNC0;
      4'd9:    wval = V_SYNC1;
      4'd10:   wval = SWIZZLE;
      4'd11:   wval = PCLK_POL;
      default: wval = PCLK_DIV;
    endcase
  end

  assign elapsed  = tick && (cnt + 1'b1 == tgt);
  assign last_cmd = (cidx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PDLO;
      cnt   <= '0;
      cidx  <= '0;
      polls <= '0;
      widx  <= '0;
    end else begin
      case (st)
        S_PDLO, S_PDHI, S_DELAY: begin
          if (elapsed) begin
            cnt <= '0;
            if (st == S_PDLO)
              st <= S_PDHI;
            else if (st == S_PDHI)
              st <= S_HOST;
            else if (last_cmd)
              st <= S_POLL;
            else begin
              cidx <= cidx + 1'b1;
              st   <= S_HOST;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOST: begin
          if (rsp_done) begin
            if (hdly != '0)
              st <= S_DELAY;
            else if (last_cmd)
              st <= S_POLL;
            else
              cidx <= cidx + 1'b1;
          end
        end
        S_POLL: begin
          if (rsp_done) begin
            if (rsp_rdata == ID_VALUE) begin
              st   <= S_WRITE;
              widx <= '0;
            end else if (polls == PW'(POLL_LIMIT - 1)) begin
              st <= S_ERR;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        S_WRITE: begin
          if (rsp_done) begin
            if (widx == 4'(NWR - 1))
              st <= S_DONE;
            else
              widx <= widx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign pd_n      = (st != S_PDLO);
  assign req_valid = (st == S_HOST) || (st == S_POLL) || (st == S_WRITE);
  assign done      = (st == S_DONE);
  assign err       = (st == S_ERR);

  always_comb begin
    req_op    = 2'd0;
    req_addr  = '0;
    req_wdata = '0;
    case (st)
      S_HOST:  req_addr = {opc, 16'h0000};
      S_POLL: begin
        req_op   = 2'd1;
        req_addr = ID_ADDR;
      end
      S_WRITE: begin
        req_op    = (widx < 4'(NWIDE)) ? 2'd3 : 2'd2;
        req_addr  = CFG_BASE + {18'd0, widx, 2'b00};
        req_wdata = wval;
      end
      default: ;
    endcase
  end

  assert_quiet_in_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> !req_valid);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> (req_valid && $stable(req_op) &&
                                  $stable(req_addr) && $stable(req_wdata)));

  assert_err_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !req_valid && !done));

  assert_pclk_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(rsp_done) && $past(req_addr) == CFG_BASE + 24'd48));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !req_valid));

endmodule

// File: tb/disp_boot_seq_tb.sv
module disp_boot_seq_tb;
  localparam int TPM  = 3;
  localparam int PLIM = 5;
  localparam logic [23:0] IDA = 24'h0C0000;
  localparam logic [23:0] CFB = 24'h102428;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        rsp_done = 1'b0;
  logic [7:0]  rsp_rdata = 8'h00;
  logic        pd_n, req_valid, done, err;
  logic [1:0]  req_op;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;

  always #5 clk = ~clk;

  disp_boot_seq #(
    .TICKS_PER_MS(TPM), .POLL_LIMIT(PLIM), .ID_ADDR(IDA), .CFG_BASE(CFB),
    .H_CYCLE(16'd548), .H_OFFSET(16'd43), .H_SIZE(16'd480), .H_SYNC0(16'd3),
    .H_SYNC1(16'd41), .V_CYCLE(16'd292), .V_OFFSET(16'd12), .V_SIZE(16'd272),
    .V_SYNC0(16'd2), .V_SYNC1(16'd10), .SWIZZLE(16'd6), .PCLK_POL(16'd1),
    .PCLK_DIV(16'd5)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pd_n(pd_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .done(done), .err(err)
  );

  function automatic logic [15:0] exp_val(int i);
    case (i)
      0: return 16'd548;  1: return 16'd43;  2: return 16'd480;
      3: return 16'd3;    4: return 16'd41;  5: return 16'd292;
      6: return 16'd12;   7: return 16'd272; 8: return 16'd2;
      9: return 16'd10;   10: return 16'd6;  11: return 16'd1;
      default: return 16'd5;
    endcase
  endfunction

  function automatic logic [7:0] exp_opc(int k);
    case (k)
      0: return 8'h00; 1: return 8'h44; 2: return 8'h62; default: return 8'h68;
    endcase
  endfunction

  int cyc = 0, lat = 2, match_at = 3, busy = 0, lat_cnt = 0;
  int nrd = 0, ntx = 0, gapc = 0, plo = 0, phi = 0, unstable = 0, pdq = 0;
  int checks = 0, fails = 0;
  logic [1:0]  lop [0:63];
  logic [23:0] ladr[0:63];
  logic [15:0] lwd [0:63];
  int          lgap[0:63];

  function automatic logic [7:0] id_reply(int n);
    if (match_at != 0 && n == match_at - 1) return 8'h7C;
    case (n % 4)
      0: return 8'h7D; 1: return 8'hFC; 2: return 8'h00; default: return 8'h3C;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    tick = (cyc % 4 == 0);
    rsp_done = 1'b0;
    if (!rst_n) begin
      busy = 0;
    end else if (busy != 0) begin
      if (lat_cnt == 0) begin
        rsp_done = 1'b1;
        busy = 0;
        if (ntx <= 64 && lop[ntx-1] == 2'd1) begin
          rsp_rdata = id_reply(nrd);
          nrd++;
        end else begin
          rsp_rdata = 8'h7C;
        end
      end else begin
        lat_cnt--;
      end
    end else if (req_valid) begin
      busy = 1;
      lat_cnt = lat;
      if (ntx < 64) begin
        lop[ntx]  = req_op;
        ladr[ntx] = req_addr;
        lwd[ntx]  = req_wdata;
        lgap[ntx] = gapc;
      end
      gapc = 0;
      ntx++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick && !pd_n) plo++;
      if (tick && pd_n && ntx == 0 && !req_valid) phi++;
      if (tick && !req_valid) gapc++;
      if (req_valid && !pd_n) pdq++;
      if (busy != 0 && ntx <= 64 &&
          (!req_valid || req_op != lop[ntx-1] || req_addr != ladr[ntx-1] ||
           req_wdata != lwd[ntx-1]))
        unstable++;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(int m, int l);
    int er, succ, wd, base;
    rst_n = 1'b0;
    match_at = m;
    lat = l;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ntx = 0; nrd = 0; gapc = 0; plo = 0; phi = 0; unstable = 0; pdq = 0;
    check("R1 reset outputs {pd_n,req_valid,done,err}",
          {pd_n, req_valid, done, err}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release {pd_n,req_valid,done,err}",
          {pd_n, req_valid, done, err}, 4'b0000);
    wd = 0;
    while (!done && !err && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    check("R10 watchdog", wd < 20000, 1);
    repeat (40) @(negedge clk);

    succ = (m != 0 && m <= PLIM) ? 1 : 0;
    er   = succ ? m : PLIM;
    check("R1 pd_n low ticks", plo, 20 * TPM);
    check("R1 no request while pd_n low", pdq, 0);
    check("R2 ticks pd_n high before first request", phi, 20 * TPM);
    for (int k = 0; k < 4; k++)
      check("R3 host command op/addr/data", {lop[k], ladr[k], lwd[k]},
            {2'd0, exp_opc(k), 16'h0000, 16'h0000});
    check("R4 wake pause ticks", lgap[1], 20 * TPM);
    check("R4 oscillator pause ticks", lgap[2], 10 * TPM);
    check("R4 PLL pause ticks", lgap[3], 10 * TPM);
    check("R4 no pause after core reset", lgap[4], 0);
    check("R5 request stable until completion", unstable, 0);
    check("R6 identity reads answered", nrd, er);
    for (int k = 4; k < 4 + er; k++)
      check("R6 identity read op/addr", {lop[k], ladr[k]}, {2'd1, IDA});
    check("R7 err", err, !succ);
    check("R10 done", done, succ);
    check("R7 R10 total requests", ntx, 4 + er + (succ ? 13 : 0));
    check("R10 idle after finish", req_valid, 0);
    if (succ != 0) begin
      base = 4 + er;
      for (int i = 0; i < 13; i++)
        check("R8 write op/addr/data", {lop[base+i], ladr[base+i], lwd[base+i]},
              {(i < 10) ? 2'd3 : 2'd2, CFB + 24'(4 * i), exp_val(i)});
      check("R9 last write is pixel clock divider", {ladr[base+12], lwd[base+12]},
            {CFB + 24'd48, 16'd5});
    end
  endtask

  initial begin
    run(3, 2);
    run(PLIM, 0);
    run(0, 1);
    run(1, 3);
    run(6, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 reset clears err/done", {done, err, pd_n}, 3'b000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule